// File: doc/BRIEF.md
# Sleep State Entry Sequencer

This block moves a system from the working state into one of the sleep levels S1 to S5. Software requests a level by writing a register image that holds a three-bit level field and a go bit. A valid request is held pending for one cycle. Then a graceful entry starts. The block raises a handshake request toward the processor and waits for an acknowledge or for a bounded timeout. After that it reports the requested level as entered.

A second path needs no software. A debounced power-button input is timed against a slow tick from the always-on clock domain. When the button has been held for a set number of ticks, the block forces S5 at once. This path skips the processor handshake.

While a sleep request is pending or in progress, the block blocks every form of throttling, including thermal throttling. It also withholds the grant for processor low-power (Cx) entry, so that sleep and Cx entry never overlap.

Top module: `sleep_entry_seq`

## Requirements
- R1: After reset, `sleep_state` reads 0 (S0, working), and `go_pending`, `hs_req` and `throttle_block` read 0.
- R2: A write with `reg_go`=1 and `reg_type` in 1..5 while the block is in S0 and idle sets `go_pending` on the next edge. The bit clears itself on the edge after that, and `hs_req` rises on that same edge.
- R3: A write whose `reg_type` is 0, 6 or 7, or whose `reg_go` is 0, is ignored. `go_pending` stays 0 and `sleep_state` stays 0. No written value selects a level outside S1..S5.
- R4: If `hs_ack` is high at an edge while `hs_req` is high, `sleep_state` takes the requested level (1..5) on that edge and `hs_req` drops.
- R5: If no acknowledge arrives, the level is entered on the ACK_TIMEOUT-th edge after `hs_req` rose (default 16).
- R6: `throttle_block` is high while a request is pending or a sleep entry is in progress or complete. While it is high, `throttle_en` is 0 even when `therm_req` is high. Otherwise `throttle_en` = `thr_req` OR `therm_req`.
- R7: `cx_grant` equals `cx_req` while `throttle_block` is 0, and is 0 while it is 1.
- R8: An edge on which `pwr_btn` is high and `slow_tick` counts the OVR_TICKS-th tick of the current press (default 5) sets `sleep_state` to 5 on that edge. This happens from any state, including during a graceful handshake, and `hs_req` drops without any acknowledge. It fires at most once per press.
- R9: Releasing `pwr_btn` for any cycle clears the tick count, so ticks from an earlier press never add to a later one.
- R10: A write made while a request is pending or an entry is under way is ignored. The level already latched is the one entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_type | input | 3 | Requested level: 1..5 = S1..S5, others invalid |
| reg_go | input | 1 | Go bit of the write |
| go_pending | output | 1 | Readback of the self-clearing go bit |
| slow_tick | input | 1 | One-cycle pulse from the always-on time base |
| pwr_btn | input | 1 | Debounced power button, 1 = pressed |
| cx_req | input | 1 | Processor low-power entry request |
| thr_req | input | 1 | Software throttle request |
| therm_req | input | 1 | Thermal throttle request |
| hs_ack | input | 1 | Graceful handshake acknowledge |
| cx_grant | output | 1 | Cx entry permitted |
| throttle_en | output | 1 | Throttling active |
| throttle_block | output | 1 | Throttling disabled by sleep activity |
| hs_req | output | 1 | Graceful handshake request |
| sleep_state | output | 3 | Current level, 0 = S0, 1..5 = S1..S5 |

## Verification
Each result is due on a fixed edge. `go_pending` is due one edge after the write. `hs_req` is due two edges after the write. The entered level is due on the edge that samples `hs_ack` or the final tick, and the timeout entry is due ACK_TIMEOUT edges after `hs_req` rose. `throttle_en`, `cx_grant` and `throttle_block` settle in the same cycle as the state they depend on. The bench drives every input on a falling edge and samples on the following falling edge. So each check sees exactly the state after the intended rising edge, and the timeout and tick windows are checked one edge before and on the edge where the change is due.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

   typedef logic [2:0] slp_lvl_t;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_GRACE = 2'd1,
      SEQ_DOWN  = 2'd2
   } seq_fsm_e;

   localparam slp_lvl_t LVL_WORK = 3'd0;
   localparam slp_lvl_t LVL_MIN  = 3'd1;
   localparam slp_lvl_t LVL_MAX  = 3'd5;
   localparam slp_lvl_t LVL_OFF  = 3'd5;

   function automatic logic lvl_ok(input slp_lvl_t lvl);
      return (lvl >= LVL_MIN) && (lvl <= LVL_MAX);
   endfunction

endpackage

// File: rtl/sleep_req_latch.sv
module sleep_req_latch
   import sleep_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_stb,
   input  slp_lvl_t wr_lvl,
   input  logic     wr_go,
   input  logic     idle,
   input  logic     kill,
   output logic     pending,
   output slp_lvl_t target
);

   logic accept;
   logic take;

   assign accept = wr_stb && wr_go && lvl_ok(wr_lvl) && idle && !pending;
   assign take   = pending && idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         target  <= LVL_WORK;
      end else if (kill) begin
         pending <= 1'b0;
      end else if (take) begin
         pending <= 1'b0;
      end else if (accept) begin
         pending <= 1'b1;
         target  <= wr_lvl;
      end
   end

   AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> !pending); // R2

   AST_BAD_TYPE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_go && !lvl_ok(wr_lvl) && !pending) |=> !pending); // R3

   AST_TARGET_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> lvl_ok(target)); // R3

endmodule

// File: rtl/btn_hold_timer.sv
module btn_hold_timer #(
   parameter int unsigned OVR_TICKS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic btn,
   output logic fire
);

   localparam int unsigned CW = $clog2(OVR_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(OVR_TICKS - 1);

   if (OVR_TICKS < 1) begin : g_bad_ticks
      $error("OVR_TICKS must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          fired;

   assign fire = btn && tick && !fired && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (!btn) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (fire) begin
         fired <= 1'b1;
      end else if (tick && !fired) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_ONE_FIRE_PER_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire); // R8

   AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !btn |=> (cnt == '0)); // R9

endmodule

// File: rtl/sleep_entry_fsm.sv
module sleep_entry_fsm
   import sleep_seq_pkg::*;
#(
   parameter int unsigned ACK_TIMEOUT = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pending,
   input  slp_lvl_t target,
   input  logic     hs_ack,
   input  logic     force_off,
   output logic     idle,
   output logic     busy,
   output logic     hs_req,
   output slp_lvl_t lvl
);

   seq_fsm_e fsm;
   logic     to_hit;

   if (ACK_TIMEOUT > 0) begin : g_timeout
      localparam int unsigned TW = $clog2(ACK_TIMEOUT + 1);
      localparam logic [TW-1:0] TO_LAST = TW'(ACK_TIMEOUT - 1);
      logic [TW-1:0] tcnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tcnt <= '0;
         end else if (fsm == SEQ_GRACE) begin
            tcnt <= tcnt + 1'b1;
         end else begin
            tcnt <= '0;
         end
      end

      assign to_hit = (fsm == SEQ_GRACE) && (tcnt == TO_LAST);

      AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         (fsm == SEQ_GRACE) |-> (tcnt <= TO_LAST)); // R5
   end else begin : g_wait_forever
      assign to_hit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm <= SEQ_IDLE;
         lvl <= LVL_WORK;
      end else if (force_off) begin
         fsm <= SEQ_DOWN;
         lvl <= LVL_OFF;
      end else begin
         unique case (fsm)
            SEQ_IDLE:  if (pending) fsm <= SEQ_GRACE;
            SEQ_GRACE: if (hs_ack || to_hit) begin
                          fsm <= SEQ_DOWN;
                          lvl <= target;
                       end
            SEQ_DOWN:  fsm <= SEQ_DOWN;
            default:   fsm <= SEQ_IDLE;
         endcase
      end
   end

   assign idle   = (fsm == SEQ_IDLE);
   assign busy   = (fsm != SEQ_IDLE);
   assign hs_req = (fsm == SEQ_GRACE);

   AST_ACK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_req && hs_ack && !force_off) |=> (lvl == $past(target)) && !hs_req); // R4

   AST_FORCE_S5: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> (lvl == LVL_OFF) && !hs_req); // R8

   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= LVL_MAX); // R3

endmodule

// File: rtl/sleep_throttle_arb.sv
module sleep_throttle_arb (
   input  logic pending,
   input  logic busy,
   input  logic cx_req,
   input  logic thr_req,
   input  logic therm_req,
   output logic cx_grant,
   output logic throttle_en,
   output logic throttle_block
);

   assign throttle_block = pending || busy;
   assign throttle_en    = (thr_req || therm_req) && !throttle_block;
   assign cx_grant       = cx_req && !throttle_block;

endmodule

// File: rtl/sleep_entry_seq.sv
module sleep_entry_seq
   import sleep_seq_pkg::*;
#(
   parameter int unsigned OVR_TICKS   = 5,
   parameter int unsigned ACK_TIMEOUT = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [2:0] reg_type,
   input  logic       reg_go,
   output logic       go_pending,
   input  logic       slow_tick,
   input  logic       pwr_btn,
   input  logic       cx_req,
   input  logic       thr_req,
   input  logic       therm_req,
   input  logic       hs_ack,
   output logic       cx_grant,
   output logic       throttle_en,
   output logic       throttle_block,
   output logic       hs_req,
   output logic [2:0] sleep_state
);

   logic     idle;
   logic     busy;
   logic     fire;
   slp_lvl_t target;

   sleep_req_latch u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (reg_wr),
      .wr_lvl  (reg_type),
      .wr_go   (reg_go),
      .idle    (idle),
      .kill    (fire),
      .pending (go_pending),
      .target  (target)
   );

   btn_hold_timer #(.OVR_TICKS(OVR_TICKS)) u_btn (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (slow_tick),
      .btn   (pwr_btn),
      .fire  (fire)
   );

   sleep_entry_fsm #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (go_pending),
      .target    (target),
      .hs_ack    (hs_ack),
      .force_off (fire),
      .idle      (idle),
      .busy      (busy),
      .hs_req    (hs_req),
      .lvl       (sleep_state)
   );

   sleep_throttle_arb u_arb (
      .pending        (go_pending),
      .busy           (busy),
      .cx_req         (cx_req),
      .thr_req        (thr_req),
      .therm_req      (therm_req),
      .cx_grant       (cx_grant),
      .throttle_en    (throttle_en),
      .throttle_block (throttle_block)
   );

   AST_NO_THROTTLE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_req || sleep_state != 3'd0) |-> !throttle_en); // R6

   AST_CX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cx_grant |-> (sleep_state == 3'd0) && !hs_req && !go_pending); // R7

   AST_HS_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      hs_req |-> (sleep_state == 3'd0)); // R4

endmodule

// File: tb/sleep_entry_seq_tb_top.sv
`timescale 1ns/1ps
module sleep_entry_seq_tb_top;

   localparam int unsigned OVR_TICKS   = 5;
   localparam int unsigned ACK_TIMEOUT = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_type = 3'd0;
   logic       reg_go = 1'b0;
   logic       go_pending;
   logic       slow_tick = 1'b0;
   logic       pwr_btn = 1'b0;
   logic       cx_req = 1'b0;
   logic       thr_req = 1'b0;
   logic       therm_req = 1'b0;
   logic       hs_ack = 1'b0;
   logic       cx_grant;
   logic       throttle_en;
   logic       throttle_block;
   logic       hs_req;
   logic [2:0] sleep_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sleep_entry_seq #(.OVR_TICKS(OVR_TICKS), .ACK_TIMEOUT(ACK_TIMEOUT)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_type(reg_type), .reg_go(reg_go),
      .go_pending(go_pending), .slow_tick(slow_tick), .pwr_btn(pwr_btn), .cx_req(cx_req),
      .thr_req(thr_req), .therm_req(therm_req), .hs_ack(hs_ack), .cx_grant(cx_grant),
      .throttle_en(throttle_en), .throttle_block(throttle_block), .hs_req(hs_req),
      .sleep_state(sleep_state)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_wr = 0; reg_go = 0; reg_type = 0; slow_tick = 0;
      pwr_btn = 0; cx_req = 0; thr_req = 0; therm_req = 0; hs_ack = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one write cycle; returns at the negedge after the sampling edge
   task automatic reg_write(input logic [2:0] t, input logic go);
      reg_wr = 1'b1; reg_type = t; reg_go = go;
      @(negedge clk);
      reg_wr = 1'b0; reg_go = 1'b0; reg_type = 3'd0;
   endtask

   task automatic one_tick();
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1", "sleep_state", sleep_state, 0);
      chk("R1", "go_pending", go_pending, 0);
      chk("R1", "hs_req", hs_req, 0);
      chk("R1", "throttle_block", throttle_block, 0);
   endtask

   task automatic t_ack_entry(input logic [2:0] t);
      do_reset();
      reg_write(t, 1'b1);
      chk("R2", "go_pending after write", go_pending, 1);
      chk("R2", "hs_req not yet", hs_req, 0);
      @(negedge clk);
      chk("R2", "go_pending self-cleared", go_pending, 0);
      chk("R2", "hs_req raised", hs_req, 1);
      @(negedge clk);
      chk("R4", "still waiting", sleep_state, 0);
      hs_ack = 1'b1;
      @(negedge clk);
      hs_ack = 1'b0;
      chk("R4", "level entered on ack", sleep_state, t);
      chk("R4", "hs_req dropped", hs_req, 0);
   endtask

   task automatic t_invalid_writes();
      do_reset();
      reg_write(3'd0, 1'b1);
      chk("R3", "type 0 pending", go_pending, 0);
      reg_write(3'd6, 1'b1);
      chk("R3", "type 6 pending", go_pending, 0);
      reg_write(3'd7, 1'b1);
      chk("R3", "type 7 pending", go_pending, 0);
      reg_write(3'd3, 1'b0);
      chk("R3", "go=0 pending", go_pending, 0);
      @(negedge clk);
      chk("R3", "no handshake", hs_req, 0);
      chk("R3", "state stays S0", sleep_state, 0);
   endtask

   task automatic t_timeout();
      do_reset();
      reg_write(3'd2, 1'b1);
      @(negedge clk);
      chk("R5", "hs_req raised", hs_req, 1);
      for (int i = 0; i < int'(ACK_TIMEOUT) - 1; i++) @(negedge clk);
      chk("R5", "one edge before timeout", sleep_state, 0);
      chk("R5", "hs_req before timeout", hs_req, 1);
      @(negedge clk);
      chk("R5", "entered on timeout", sleep_state, 2);
   endtask

   task automatic t_throttle_cx();
      do_reset();
      thr_req = 1'b0; therm_req = 1'b1; cx_req = 1'b1;
      @(negedge clk);
      chk("R6", "thermal throttle when idle", throttle_en, 1);
      chk("R7", "cx grant when idle", cx_grant, 1);
      reg_write(3'd1, 1'b1);
      chk("R6", "block while pending", throttle_block, 1);
      chk("R6", "thermal overridden", throttle_en, 0);
      chk("R7", "cx withheld while pending", cx_grant, 0);
      @(negedge clk);
      thr_req = 1'b1;
      #1;
      chk("R6", "throttle off in handshake", throttle_en, 0);
      chk("R7", "cx withheld in handshake", cx_grant, 0);
   endtask

   task automatic t_override_graceful();
      do_reset();
      reg_write(3'd3, 1'b1);
      @(negedge clk);
      chk("R8", "in handshake", hs_req, 1);
      pwr_btn = 1'b1;
      for (int i = 0; i < int'(OVR_TICKS) - 1; i++) one_tick();
      chk("R8", "not yet forced", sleep_state, 0);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      chk("R8", "forced S5 without ack", sleep_state, 5);
      chk("R8", "hs_req dropped", hs_req, 0);
      pwr_btn = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_release_clears();
      do_reset();
      pwr_btn = 1'b1;
      for (int i = 0; i < int'(OVR_TICKS) - 1; i++) one_tick();
      pwr_btn = 1'b0;
      @(negedge clk);
      pwr_btn = 1'b1;
      for (int i = 0; i < int'(OVR_TICKS) - 1; i++) one_tick();
      chk("R9", "earlier ticks not counted", sleep_state, 0);
      one_tick();
      chk("R9", "full hold forces S5", sleep_state, 5);
      pwr_btn = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_busy_write();
      do_reset();
      reg_write(3'd4, 1'b1);
      reg_write(3'd2, 1'b1);
      chk("R10", "write in pending cycle ignored", go_pending, 0);
      reg_write(3'd1, 1'b1);
      chk("R10", "write in handshake ignored", go_pending, 0);
      hs_ack = 1'b1;
      @(negedge clk);
      hs_ack = 1'b0;
      chk("R10", "latched level kept", sleep_state, 4);
   endtask

   initial begin
      t_reset_state();
      t_ack_entry(3'd1);
      t_ack_entry(3'd5);
      t_invalid_writes();
      t_timeout();
      t_throttle_cx();
      t_override_graceful();
      t_release_clears();
      t_busy_write();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule